// File: doc/BRIEF.md
# Four-Mode Split 16-bit Timer/Counter

This block is a 16-bit timer/counter built from two 8-bit halves. Time is counted in instruction cycles, marked by a one-clock `cyc_en` pulse. Those cycles pass through a fixed divide-by-four prescaler and then a programmable prescaler. An external event input feeds the halves through a synchronizer and a rising-edge detector. A 2-bit mode register sets how the halves are clocked:

- as two independent timers;
- as a timer in the low half and an event counter in the high half;
- as one cascaded 16-bit timer;
- as one cascaded 16-bit event counter.

Each half runs from zero up to its reload value and then wraps to zero. On that wrap it raises its own sticky interrupt flag, which software clears with a write-one strobe. While `run_en` is low, nothing advances. Software sets up the block while it is stopped. A reload written at that time restarts the matching half and the prescaler chain from zero.

Top module: `mm_timer16`

## Requirements
- R1: After reset both flags are 0, both counters and both prescaler stages are 0, and the reload registers, the prescale value and the mode all hold 0.
- R2: While running, a prescaled timer tick occurs once every 4*(P+1) cycles on which `cyc_en` is high, where P is the prescale value.
- R3: Each half counts ticks from 0 up to its reload value R. On the tick that finds the count at R it wraps to 0 and sets its flag, so its period is R+1 ticks.
- R4: In mode 2'b00 both halves are independent timers on the prescaled tick. The low flag first rises after 4*(P+1)*(RL+1) enabled cycles and the high flag after 4*(P+1)*(RH+1).
- R5: In mode 2'b01 the low half is a prescaled timer and the high half counts external rising edges. The high flag rises on edge RH+1 and never rises from `cyc_en` alone.
- R6: In mode 2'b10 the halves form one 16-bit timer on the prescaled tick. The high flag rises after 4*(P+1)*(256*RH+RL+1) enabled cycles and the low flag never rises.
- R7: In mode 2'b11 the halves form one 16-bit counter of external rising edges. The high flag rises on edge 256*RH+RL+1 and the low flag never rises.
- R8: `ext_in` passes through a two-flop synchronizer, and each rising edge counts once. In modes 2'b00 and 2'b10 external edges have no effect on either counter or flag.
- R9: While `run_en` is low, counters, prescalers and flags hold their values. Stopped time does not count toward a period.
- R10: A reload write made while stopped clears that half's counter and both prescaler stages. It leaves the other half's counter untouched.
- R11: Flags are sticky. `flag_clr` bit 0 clears the low flag and bit 1 clears the high flag, and a set in the same cycle wins.
- R12: Register writes use `wr_addr`: 0 is the low reload, 1 the high reload, 2 the prescale value and 3 the mode, with the mode taken from `wr_data[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-clock pulse per instruction cycle |
| run_en | input | 1 | Timer runs while high |
| ext_in | input | 1 | Asynchronous external event input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | HALF_W | Write data |
| flag_clr | input | 2 | Write-one-to-clear strobes for the low (bit 0) and high (bit 1) flags |
| irq_lo | output | 1 | Low-half interrupt flag |
| irq_hi | output | 1 | High-half interrupt flag |

## Verification
The bench builds the block with its default parameters: 8-bit halves, a 2-bit fixed prescaler, an 8-bit programmable prescaler and a two-stage synchronizer. It holds the prescale and reload values small so that full periods stay short, which puts each first flag edge on an exact cycle the bench can compare against. Sweeps over prescale and reload pairs cover all four modes. A cascaded run with the high reload at one makes the low byte carry into the high byte within a few hundred events or about a thousand cycles.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   typedef enum logic [1:0] {
      MODE_DUAL8 = 2'b00,
      MODE_T8_E8 = 2'b01,
      MODE_T16   = 2'b10,
      MODE_E16   = 2'b11
   } mmt_mode_e;

   localparam logic [1:0] ADDR_RLD_LO = 2'd0;
   localparam logic [1:0] ADDR_RLD_HI = 2'd1;
   localparam logic [1:0] ADDR_PRE    = 2'd2;
   localparam logic [1:0] ADDR_MODE   = 2'd3;

endpackage

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
   parameter int FIX_W = 2,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             cyc_en,
   input  logic             clr,
   input  logic [PRE_W-1:0] pre_val,
   output logic             pre_tick
);

   generate
      if (FIX_W < 1) begin : g_bad_fix
         $error("mmt_prescale: FIX_W must be at least 1");
      end
      if (PRE_W < 1) begin : g_bad_pre
         $error("mmt_prescale: PRE_W must be at least 1");
      end
   endgenerate

   logic [FIX_W-1:0] fix_cnt;
   logic [PRE_W-1:0] pre_cnt;
   logic             adv;
   logic             fix_tick;

   assign adv      = run & cyc_en;
   assign fix_tick = adv & (fix_cnt == {FIX_W{1'b1}});
   assign pre_tick = fix_tick & (pre_cnt >= pre_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_cnt <= '0;
         pre_cnt <= '0;
      end else if (clr) begin
         fix_cnt <= '0;
         pre_cnt <= '0;
      end else if (adv) begin
         fix_cnt <= fix_cnt + 1'b1;
         if (fix_tick) begin
            pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
         end
      end
   end

   // R2 / R9: the fixed stage only moves on an enabled cycle
   assert_fix_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(fix_cnt));

   // R2: a programmable tick is always on a fixed-stage rollover
   assert_tick_on_roll_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_tick && !clr) |=> (fix_cnt == '0));

endmodule

// File: rtl/mmt_sync_edge.sv
module mmt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mmt_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         prev <= 1'b0;
      end else begin
         sr   <= {sr[STAGES-2:0], din};
         prev <= sr[STAGES-1];
      end
   end

   assign rise = sr[STAGES-1] & ~prev;

   // R8: one event per rising edge, never two in a row
   assert_single_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/mmt_half.sv
module mmt_half #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   input  logic [W-1:0] lim,
   output logic [W-1:0] cnt,
   output logic         at_lim
);

   assign at_lim = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= at_lim ? '0 : cnt + 1'b1;
      end
   end

   // R3: a tick at the limit wraps the half to zero
   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_lim) |=> (cnt == '0));

   // R3: a tick below the limit advances by exactly one
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !at_lim && !clr) |=> (cnt == $past(cnt) + 1'b1));

   // R9: without tick or clear the count holds
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
   import mmt_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int FIX_W       = 2,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              run_en,
   input  logic              ext_in,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [HALF_W-1:0] wr_data,
   input  logic [1:0]        flag_clr,
   output logic              irq_lo,
   output logic              irq_hi
);

   localparam logic [HALF_W-1:0] HALF_MAX = {HALF_W{1'b1}};

   generate
      if (HALF_W < 2) begin : g_bad_half
         $error("mm_timer16: HALF_W must be at least 2");
      end
      if (PRE_W > HALF_W) begin : g_bad_prew
         $error("mm_timer16: PRE_W must not exceed HALF_W");
      end
   endgenerate

   logic [HALF_W-1:0] rld_lo, rld_hi;
   logic [PRE_W-1:0]  pre_val;
   mmt_mode_e         mode;

   logic wr_rl, wr_rh, wr_pre, wr_mode;
   logic clr_lo_cnt, clr_hi_cnt, clr_pre;
   logic pre_tick, ext_rise, ev;
   logic cascade;
   logic lo_src, hi_src;
   logic [HALF_W-1:0] lo_lim;
   logic [HALF_W-1:0] lo_cnt, hi_cnt;
   logic lo_at, hi_at;
   logic lo_hit, hi_hit;

   // register decode
   assign wr_rl   = wr_en & (wr_addr == ADDR_RLD_LO);
   assign wr_rh   = wr_en & (wr_addr == ADDR_RLD_HI);
   assign wr_pre  = wr_en & (wr_addr == ADDR_PRE);
   assign wr_mode = wr_en & (wr_addr == ADDR_MODE);

   assign clr_lo_cnt = wr_rl & ~run_en;
   assign clr_hi_cnt = wr_rh & ~run_en;
   assign clr_pre    = (wr_rl | wr_rh) & ~run_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_lo  <= '0;
         rld_hi  <= '0;
         pre_val <= '0;
         mode    <= MODE_DUAL8;
      end else begin
         if (wr_rl)   rld_lo  <= wr_data;
         if (wr_rh)   rld_hi  <= wr_data;
         if (wr_pre)  pre_val <= wr_data[PRE_W-1:0];
         if (wr_mode) mode    <= mmt_mode_e'(wr_data[1:0]);
      end
   end

   mmt_prescale #(.FIX_W(FIX_W), .PRE_W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_en),
      .cyc_en   (cyc_en),
      .clr      (clr_pre),
      .pre_val  (pre_val),
      .pre_tick (pre_tick)
   );

   mmt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_in),
      .rise  (ext_rise)
   );

   assign ev      = ext_rise & run_en;
   assign cascade = (mode == MODE_T16) || (mode == MODE_E16);

   // clock routing per mode
   always_comb begin
      lo_src = pre_tick;
      hi_src = pre_tick;
      lo_lim = rld_lo;
      unique case (mode)
         MODE_DUAL8: begin
            lo_src = pre_tick;
            hi_src = pre_tick;
         end
         MODE_T8_E8: begin
            lo_src = pre_tick;
            hi_src = ev;
         end
         MODE_T16: begin
            lo_src = pre_tick;
            hi_src = pre_tick & lo_at;
            lo_lim = hi_at ? rld_lo : HALF_MAX;
         end
         MODE_E16: begin
            lo_src = ev;
            hi_src = ev & lo_at;
            lo_lim = hi_at ? rld_lo : HALF_MAX;
         end
         default: ;
      endcase
   end

   mmt_half #(.W(HALF_W)) u_lo (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (lo_src),
      .clr    (clr_lo_cnt),
      .lim    (lo_lim),
      .cnt    (lo_cnt),
      .at_lim (lo_at)
   );

   mmt_half #(.W(HALF_W)) u_hi (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (hi_src),
      .clr    (clr_hi_cnt),
      .lim    (rld_hi),
      .cnt    (hi_cnt),
      .at_lim (hi_at)
   );

   assign lo_hit = ~cascade & lo_src & lo_at;
   assign hi_hit = hi_src & hi_at;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_lo <= 1'b0;
         irq_hi <= 1'b0;
      end else begin
         irq_lo <= lo_hit | (irq_lo & ~flag_clr[0]);
         irq_hi <= hi_hit | (irq_hi & ~flag_clr[1]);
      end
   end

   // R9: stopped and untouched means frozen
   assert_stopped_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_en) |=> ($stable(lo_cnt) && $stable(hi_cnt)));

   // R6 / R7: cascaded modes never raise the low flag
   assert_no_lo_flag_cascade_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade && !irq_lo && !wr_mode) |=> !irq_lo);

   // R8: in dual-timer mode only the prescaler moves the counters
   assert_ext_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DUAL8 && !pre_tick && !wr_en) |=> ($stable(lo_cnt) && $stable(hi_cnt)));

   // R11: flags are sticky without a clear strobe
   assert_sticky_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lo && !flag_clr[0]) |=> irq_lo);
   assert_sticky_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_hi && !flag_clr[1]) |=> irq_hi);

   // R10: a stopped reload write restarts its half
   assert_reload_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rl && !run_en) |=> (lo_cnt == '0));

endmodule

// File: tb/mm_timer16_tb.sv
module mm_timer16_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b0;
   logic       run_en = 1'b0;
   logic       ext_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] flag_clr = 2'b00;
   logic       irq_lo, irq_hi;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_count = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mm_timer16 u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_en   (cyc_en),
      .run_en   (run_en),
      .ext_in   (ext_in),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .flag_clr (flag_clr),
      .irq_lo   (irq_lo),
      .irq_hi   (irq_hi)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 2'(addr);
      wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // R12: address 3 mode, 2 prescale, 0 low reload, 1 high reload
   task automatic setup(input int m, input int p, input int rl, input int rh);
      run_en = 1'b0;
      cyc_en = 1'b0;
      ext_in = 1'b0;
      write_reg(3, m);
      write_reg(2, p);
      write_reg(0, rl);
      write_reg(1, rh);
      @(negedge clk);
      flag_clr = 2'b11;
      @(negedge clk);
      flag_clr = 2'b00;
   endtask

   task automatic run_measure(input int limit, output int nlo, output int nhi);
      nlo = 0;
      nhi = 0;
      @(negedge clk);
      run_en = 1'b1;
      cyc_en = 1'b1;
      for (int n = 1; n <= limit; n++) begin
         @(negedge clk);
         if (irq_lo && nlo == 0) nlo = n;
         if (irq_hi && nhi == 0) nhi = n;
      end
      run_en = 1'b0;
      cyc_en = 1'b0;
   endtask

   task automatic pulse_ext();
      @(negedge clk);
      ext_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      ext_in = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc_count++;
         if (cyc_count > WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_count, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      int nlo, nhi, exp_lo, exp_hi, nfirst, nsec;
      int ps[3] = '{0, 1, 3};
      int rs[4] = '{0, 1, 4, 9};

      repeat (3) @(negedge clk);
      // R1: flags low in reset and after release
      chk(irq_lo == 1'b0 && irq_hi == 1'b0, "R1 flags in reset", {irq_hi, irq_lo}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_lo == 1'b0 && irq_hi == 1'b0, "R1 flags after reset", {irq_hi, irq_lo}, 0);
      // R1: default mode 0, reloads 0, prescale 0 -> both flags at cycle 4
      run_measure(10, nlo, nhi);
      chk(nlo == 4, "R1 default low period", nlo, 4);
      chk(nhi == 4, "R1 default high period", nhi, 4);

      // R2 R4: mode 0 sweep
      foreach (ps[i]) begin
         foreach (rs[j]) begin
            setup(0, ps[i], rs[j], rs[j] + 2);
            exp_lo = 4 * (ps[i] + 1) * (rs[j] + 1);
            exp_hi = 4 * (ps[i] + 1) * (rs[j] + 3);
            run_measure(exp_hi + 4, nlo, nhi);
            chk(nlo == exp_lo, "R4 R2 mode0 low first flag", nlo, exp_lo);
            chk(nhi == exp_hi, "R4 R2 mode0 high first flag", nhi, exp_hi);
         end
      end

      // R3: period after wrap
      setup(0, 0, 2, 200);
      nfirst = 0;
      nsec = 0;
      @(negedge clk);
      run_en = 1'b1;
      cyc_en = 1'b1;
      for (int n = 1; n <= 40; n++) begin
         @(negedge clk);
         if (nfirst != 0 && n == nfirst + 1) flag_clr = 2'b00;
         if (irq_lo) begin
            if (nfirst == 0) begin
               nfirst = n;
               flag_clr = 2'b01;
            end else if (n > nfirst + 1 && nsec == 0) begin
               nsec = n;
            end
         end
      end
      run_en = 1'b0;
      cyc_en = 1'b0;
      chk(nfirst == 12, "R3 first wrap", nfirst, 12);
      chk(nsec == 24, "R3 second wrap", nsec, 24);

      // R5: mode 1 low is a timer, high ignores cycles
      setup(1, 0, 2, 0);
      run_measure(40, nlo, nhi);
      chk(nlo == 12, "R5 mode1 low timer", nlo, 12);
      chk(nhi == 0, "R5 mode1 high ignores cycles", nhi, 0);

      // R5 R8: mode 1 high counts external edges
      for (int r = 0; r < 8; r += 3) begin
         setup(1, 0, 5, r);
         @(negedge clk);
         run_en = 1'b1;
         for (int k = 0; k < r; k++) pulse_ext();
         chk(irq_hi == 1'b0, "R5 mode1 high before last edge", irq_hi, 0);
         pulse_ext();
         chk(irq_hi == 1'b1, "R5 mode1 high after last edge", irq_hi, 1);
         chk(irq_lo == 1'b0, "R8 mode1 edges do not reach low", irq_lo, 0);
         run_en = 1'b0;
      end

      // R6: mode 2 cascade
      setup(2, 0, 3, 1);
      run_measure(1060, nlo, nhi);
      chk(nhi == 1040, "R6 mode2 cascade RH=1 RL=3", nhi, 1040);
      chk(nlo == 0, "R6 mode2 low flag silent", nlo, 0);
      setup(2, 1, 0, 0);
      run_measure(20, nlo, nhi);
      chk(nhi == 8, "R6 mode2 cascade zero reload", nhi, 8);
      setup(2, 0, 255, 0);
      run_measure(1040, nlo, nhi);
      chk(nhi == 1024, "R6 mode2 full low byte", nhi, 1024);
      chk(nlo == 0, "R6 mode2 low flag silent full", nlo, 0);

      // R7: mode 3 16-bit event counter
      setup(3, 0, 2, 1);
      @(negedge clk);
      run_en = 1'b1;
      cyc_en = 1'b1;
      for (int k = 0; k < 258; k++) pulse_ext();
      chk(irq_hi == 1'b0, "R7 mode3 before edge 259", irq_hi, 0);
      pulse_ext();
      chk(irq_hi == 1'b1, "R7 mode3 at edge 259", irq_hi, 1);
      chk(irq_lo == 1'b0, "R7 mode3 low flag silent", irq_lo, 0);
      run_en = 1'b0;
      cyc_en = 1'b0;

      // R8: external edges ignored in modes 0 and 2
      setup(0, 0, 0, 0);
      @(negedge clk);
      run_en = 1'b1;
      repeat (5) pulse_ext();
      chk({irq_hi, irq_lo} == 2'b00, "R8 mode0 ignores edges", {irq_hi, irq_lo}, 0);
      run_en = 1'b0;
      setup(2, 0, 0, 0);
      @(negedge clk);
      run_en = 1'b1;
      repeat (3) pulse_ext();
      chk({irq_hi, irq_lo} == 2'b00, "R8 mode2 ignores edges", {irq_hi, irq_lo}, 0);
      run_en = 1'b0;

      // R9: stopped time does not count
      setup(0, 1, 3, 200);
      nlo = 0;
      @(negedge clk);
      run_en = 1'b1;
      cyc_en = 1'b1;
      for (int n = 1; n <= 80; n++) begin
         @(negedge clk);
         if (irq_lo && nlo == 0) nlo = n;
         if (n == 10) run_en = 1'b0;
         if (n == 35) run_en = 1'b1;
      end
      run_en = 1'b0;
      cyc_en = 1'b0;
      chk(nlo == 57, "R9 pause extends period", nlo, 57);

      // R10: stopped reload write clears its half and the prescaler only
      setup(0, 1, 3, 3);
      @(negedge clk);
      run_en = 1'b1;
      cyc_en = 1'b1;
      repeat (20) @(negedge clk);
      run_en = 1'b0;
      cyc_en = 1'b0;
      write_reg(0, 3);
      run_measure(40, nlo, nhi);
      chk(nlo == 32, "R10 low restarted", nlo, 32);
      chk(nhi == 16, "R10 high kept its count", nhi, 16);

      // R11: write-one-to-clear per flag
      setup(0, 0, 0, 0);
      run_measure(8, nlo, nhi);
      chk({irq_hi, irq_lo} == 2'b11, "R11 both flags sticky", {irq_hi, irq_lo}, 3);
      @(negedge clk);
      flag_clr = 2'b01;
      @(negedge clk);
      flag_clr = 2'b00;
      chk({irq_hi, irq_lo} == 2'b10, "R11 clear low only", {irq_hi, irq_lo}, 2);
      repeat (3) @(negedge clk);
      chk(irq_hi == 1'b1, "R11 high stays set", irq_hi, 1);
      flag_clr = 2'b10;
      @(negedge clk);
      flag_clr = 2'b00;
      chk({irq_hi, irq_lo} == 2'b00, "R11 clear high", {irq_hi, irq_lo}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule